// File: doc/BRIEF.md
# Fractional Oscillator Step Modulator

This block sits next to a tunable oscillator that offers a set of discrete frequency steps. For every oscillator cycle it decides whether the oscillator runs at the requested base step or at the step just above it. A 5-bit fraction value sets how many of every 32 cycles use the higher step. The result is an average frequency that lies between two neighbouring steps.

The higher-step cycles are spread as evenly as the frame allows. They are not bunched together, so the short-term period stays close to the average. The block is driven by a strobe that marks each oscillator cycle. It reports the step to apply for the current cycle, and it raises a flag during the first cycle of each 32-cycle frame. The base step and the fraction may be rewritten at any time while the oscillator runs.

Top module: `osc_step_modulator`

## Requirements
- R1: A frame is exactly 32 oscillator cycles long. `frame_start` is 1 for the whole of the first oscillator cycle of each frame and 0 otherwise. The first strobe after reset opens a frame.
- R2: When the fraction F is held constant for a whole frame and the base step is below 7, exactly F cycles of that frame report base+1 and the other 32−F cycles report the base.
- R3: When F is constant, cycle k of a frame (k = 0..31) reports base+1 exactly when floor((k+1)·F/32) > floor(k·F/32).
- R4: With F = 16 the frame strictly alternates: the base step first, then base+1, and so on.
- R5: With F = 0 every cycle reports the base step.
- R6: With a base step of 7 (the top step) the output is always 7, whatever the value of F.
- R7: `step_base` and `frac_cnt` are sampled on the clock edge where `osc_tick` is 1. The outputs take their new values one clock after that edge. They hold steady on every clock without a strobe.
- R8: A new base step or fraction given mid-frame applies from that strobe onward, and the frame position is not restarted. Within a frame, a cycle reports base+1 when adding the current F to the running sum of the fractions applied since the frame began crosses a multiple of 32.
- R9: While reset is held and until the first strobe, `step_eff` is 0 and `frame_start` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-clock strobe marking the start of a new oscillator cycle |
| step_base | input | 3 | Requested base step, 0..7 |
| frac_cnt | input | 5 | Number of higher-step cycles per 32-cycle frame |
| step_eff | output | 3 | Step the oscillator should use for the current cycle |
| frame_start | output | 1 | High during the first oscillator cycle of each frame |

## Verification
The embedded properties watch on every clock that the outputs hold between strobes, and that the reported step is always the sampled base or the one above it. They also check that the top step is never exceeded, that a zero fraction never steps up, and that consecutive frame flags are exactly 32 strobes apart. The exact per-frame count of higher-step cycles, where those cycles fall inside the frame, strict alternation at half fraction, and the running-sum behaviour after a mid-frame change depend on a whole sequence of strobes. Only the bench scenarios show those, by comparing each cycle against an independently computed expectation.

// File: rtl/stepmod_pkg.sv
package stepmod_pkg;
  parameter int unsigned STEPMOD_STEP_W = 3;
  parameter int unsigned STEPMOD_FRAC_W = 5;
endpackage

// File: rtl/stepmod_frame_ctr.sv
module stepmod_frame_ctr #(
  parameter int unsigned FRAC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic [FRAC_W-1:0] pos,
  output logic              frame_wrap
);
  localparam logic [FRAC_W-1:0] LAST_POS = '1;

  logic [FRAC_W-1:0] pos_q;

  // Reset to the last slot so that the first strobe opens a frame.
  always_ff @(posedge clk) begin
    if (!rst_n)    pos_q <= LAST_POS;
    else if (tick) pos_q <= pos_q + 1'b1;
  end

  assign pos        = pos_q;
  assign frame_wrap = (pos_q == LAST_POS);

  // R7: frame position moves only on a strobe
  assert_pos_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pos_q));
endmodule

// File: rtl/stepmod_phase_acc.sv
module stepmod_phase_acc #(
  parameter int unsigned FRAC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              restart,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  // The phase restarts from zero at each frame boundary, so a constant
  // fraction yields exactly that many carries per frame.
  function automatic logic [FRAC_W:0] phase_add(input logic [FRAC_W-1:0] a,
                                                input logic [FRAC_W-1:0] f);
    return {1'b0, a} + {1'b0, f};
  endfunction

  assign sum   = phase_add(restart ? '0 : acc_q, frac);
  assign carry = sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (tick) acc_q <= sum[FRAC_W-1:0];
  end

  // R5: a zero fraction never produces a step-up request
  assert_zero_frac_no_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frac == '0) |-> !carry);
  // R7: phase moves only on a strobe
  assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(acc_q));
endmodule

// File: rtl/stepmod_step_sel.sv
module stepmod_step_sel #(
  parameter int unsigned STEP_W = 3
) (
  input  logic [STEP_W-1:0] base,
  input  logic              up_req,
  output logic [STEP_W-1:0] step,
  output logic              up_blocked
);
  localparam logic [STEP_W-1:0] TOP_STEP = '1;

  function automatic logic [STEP_W-1:0] step_pick(input logic [STEP_W-1:0] b,
                                                  input logic             up);
    if (up && b != TOP_STEP) return b + 1'b1;
    return b;
  endfunction

  assign step       = step_pick(base, up_req);
  assign up_blocked = up_req && (base == TOP_STEP);

  // R6: a blocked request leaves the step at the top value
  always_comb begin
    if (up_blocked) assert_blocked_stays_top_R6: assert (step == TOP_STEP);
  end
endmodule

// File: rtl/osc_step_modulator.sv
module osc_step_modulator
  import stepmod_pkg::*;
#(
  parameter int unsigned STEP_W = STEPMOD_STEP_W,
  parameter int unsigned FRAC_W = STEPMOD_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic [STEP_W-1:0] step_base,
  input  logic [FRAC_W-1:0] frac_cnt,
  output logic [STEP_W-1:0] step_eff,
  output logic              frame_start
);
  localparam int unsigned       FRAME_LEN = 1 << FRAC_W;
  localparam int unsigned       GAP_W     = FRAC_W + 2;
  localparam logic [STEP_W-1:0] TOP_STEP  = '1;
  localparam logic [STEP_W-1:0] STEP_ONE  = STEP_W'(1);

  logic [FRAC_W-1:0] frame_pos;
  logic              frame_wrap;
  logic              phase_carry;
  logic [STEP_W-1:0] step_next;
  logic              up_blocked;
  logic [STEP_W-1:0] step_q;
  logic              fstart_q;

  stepmod_frame_ctr #(.FRAC_W(FRAC_W)) frame_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (osc_tick),
    .pos        (frame_pos),
    .frame_wrap (frame_wrap)
  );

  stepmod_phase_acc #(.FRAC_W(FRAC_W)) phase_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (osc_tick),
    .restart (frame_wrap),
    .frac    (frac_cnt),
    .carry   (phase_carry)
  );

  stepmod_step_sel #(.STEP_W(STEP_W)) sel_i (
    .base       (step_base),
    .up_req     (phase_carry),
    .step       (step_next),
    .up_blocked (up_blocked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q   <= '0;
      fstart_q <= 1'b0;
    end else if (osc_tick) begin
      step_q   <= step_next;
      fstart_q <= frame_wrap;
    end
  end

  assign step_eff    = step_q;
  assign frame_start = fstart_q;

  // Checker-only counter: strobes seen since the last frame flag rose.
  logic [GAP_W-1:0] chk_gap;
  logic             chk_seen;
  logic             fstart_rose;
  logic             fstart_d;

  always_ff @(posedge clk) begin
    if (!rst_n) fstart_d <= 1'b0;
    else        fstart_d <= fstart_q;
  end
  assign fstart_rose = fstart_q && !fstart_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_gap  <= '0;
      chk_seen <= 1'b0;
    end else if (fstart_rose) begin
      chk_gap  <= osc_tick ? GAP_W'(1) : '0;
      chk_seen <= 1'b1;
    end else if (osc_tick) begin
      chk_gap  <= chk_gap + 1'b1;
    end
  end

  assert_frame_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fstart_rose && chk_seen) |-> (chk_gap == GAP_W'(FRAME_LEN)));

  assert_outputs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> ($stable(step_eff) && $stable(frame_start)));

  assert_step_in_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    osc_tick |=> ((step_eff == $past(step_base)) ||
                  ((step_eff == $past(step_base) + STEP_ONE) && ($past(step_base) != TOP_STEP))));

  assert_top_step_capped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_tick && step_base == TOP_STEP) |=> (step_eff == TOP_STEP));

  assert_zero_frac_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_tick && frac_cnt == '0) |=> (step_eff == $past(step_base)));
endmodule

// File: tb/osc_step_modulator_tb_top.sv
module osc_step_modulator_tb_top;
  localparam int FRAME = 32;
  localparam int MAXS  = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic [2:0] step_base = '0;
  logic [4:0] frac_cnt = '0;
  logic [2:0] step_eff;
  logic       frame_start;

  always #5 clk = ~clk;

  osc_step_modulator dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_tick    (osc_tick),
    .step_base   (step_base),
    .frac_cnt    (frac_cnt),
    .step_eff    (step_eff),
    .frame_start (frame_start)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  int  b_pos = FRAME - 1;
  int  b_total = 0;
  bit  done = 1'b0;

  // Expected step-up for one cycle: the running sum crosses a multiple of 32.
  function automatic bit bench_fast(int total, int m);
    return ((total + m) / FRAME) != (total / FRAME);
  endfunction

  function automatic int bench_step(int base, bit fast);
    if (fast && base < MAXS) return base + 1;
    return base;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_tick(int base, int m, string tag, output bit saw_up);
    int  exp;
    bit  fast;
    int  idle;
    logic [2:0] s0;
    logic       f0;
    @(negedge clk);
    step_base = base[2:0];
    frac_cnt  = m[4:0];
    osc_tick  = 1'b1;
    b_pos = (b_pos + 1) % FRAME;
    if (b_pos == 0) b_total = 0;
    fast = bench_fast(b_total, m);
    b_total += m;
    exp = bench_step(base, fast);
    @(negedge clk);
    osc_tick = 1'b0;
    check(step_eff == exp[2:0], tag, "step_eff", int'(step_eff), exp);
    check(frame_start == (b_pos == 0), "R1", "frame_start", int'(frame_start), int'(b_pos == 0));
    saw_up = (int'(step_eff) == base + 1);
    idle = $urandom_range(0, 2);
    s0 = step_eff;
    f0 = frame_start;
    if (idle > 0) begin
      step_base = 3'($urandom_range(0, 7));
      frac_cnt  = 5'($urandom_range(0, 31));
      repeat (idle) @(negedge clk);
      check(step_eff == s0 && frame_start == f0, "R7", "hold without strobe",
            int'({step_eff, frame_start}), int'({s0, f0}));
    end
  endtask

  task automatic run_frame(int base, int m, string tag);
    int n_up = 0;
    bit up;
    for (int k = 0; k < FRAME; k++) begin
      do_tick(base, m, tag, up);
      if (up) n_up++;
    end
    check(n_up == ((base < MAXS) ? m : 0), "R2", "step-up count in frame",
          n_up, (base < MAXS) ? m : 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit up;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(step_eff == 3'd0, "R9", "reset step_eff", int'(step_eff), 0);
    check(frame_start == 1'b0, "R9", "reset frame_start", int'(frame_start), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(step_eff == 3'd0 && frame_start == 1'b0, "R9", "idle after reset",
          int'({step_eff, frame_start}), 0);

    // R4: half fraction alternates, base step first
    for (int k = 0; k < FRAME; k++) begin
      do_tick(3, 16, "R4", up);
      check(int'(step_eff) == 3 + (k % 2), "R4", "alternation", int'(step_eff), 3 + (k % 2));
    end
    // R5: zero fraction
    run_frame(5, 0, "R5");
    // R6: top step never exceeded
    run_frame(7, 20, "R6");
    run_frame(7, 31, "R6");
    // R3: extremes and a few spreads
    run_frame(0, 1, "R3");
    run_frame(2, 31, "R3");
    run_frame(6, 11, "R3");
    run_frame(1, 5, "R3");

    // R8: change fraction and base mid-frame; frame position continues
    for (int k = 0; k < FRAME; k++) begin
      if (k < 10)      do_tick(4, 7, "R8", up);
      else if (k < 20) do_tick(4, 23, "R8", up);
      else             do_tick(2, 13, "R8", up);
    end
    for (int k = 0; k < 2 * FRAME; k++)
      do_tick($urandom_range(0, 7), $urandom_range(0, 31), "R8", up);

    // R2/R3: random constant frames
    for (int f = 0; f < 16; f++)
      run_frame($urandom_range(0, 7), $urandom_range(0, 31), "R3");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule